// File: doc/BRIEF.md
# Ordered Posted Write Buffer

This block sits between a processor store port and a downstream write interconnect. Every store arrives with a single attribute bit that selects one of two ordering classes: a bufferable device access or a strictly ordered access. A device store is completed towards the processor as soon as it has been placed in a small in-order queue. The processor may then move on while the store is still waiting for the interconnect, or has not yet started there. A strictly ordered store is held at the port until the endpoint has answered it, and any error from the endpoint comes back with its completion.

The address space is divided into regions by the upper address bits. Stores to one region always leave in the order the processor issued them. A strictly ordered store waits only for queued stores to its own region, so it may pass buffered stores aimed elsewhere. A barrier request is answered once nothing is queued and no downstream transaction is open. A store that was already completed early cannot return its error synchronously. Instead, an error on such a store raises a sticky flag and records the store's address. A one-cycle clear pulse resets the flag.

Top module: `posted_wr_buf`

## Requirements
- R1: A device store (req_strict = 0) is completed (req_ready = 1) in the cycle it is presented whenever the queue has room, even while the downstream port is not accepting.
- R2: While the downstream port accepts nothing, exactly DEPTH + 1 device stores are completed: DEPTH in the queue and one in the issue stage. The next one sees req_ready = 0 until an entry frees.
- R3: Stores to one region (address bits AW-1 down to REG_LSB) appear on the downstream port in issue order.
- R4: A strictly ordered store (req_strict = 1) sees req_ready = 1 only in the cycle in which the downstream response for that store is valid, and never before.
- R5: A strictly ordered store is sent downstream only after every older queued store to its own region.
- R6: A strictly ordered store may pass older queued stores to other regions. When the issue stage frees, it is sent before them.
- R7: A downstream error on a strictly ordered store is returned as req_err = 1 together with its req_ready, and it leaves the sticky flag unchanged.
- R8: A downstream error on a device store sets imp_err and loads imp_addr with that store's address. While the flag stays set, later errors neither clear it nor change imp_addr.
- R9: A one-cycle err_clr pulse clears imp_err. If a device-store error arrives in the same cycle as the pulse, the flag stays set and imp_addr takes the new store's address.
- R10: bar_ack is 1 only while bar_req is 1, the queue is empty, and no downstream transaction is requested or awaiting its response.
- R11: After reset the queue is empty: req_ready is 1 for a device store, dn_valid is 0, imp_err is 0, and a barrier is acknowledged at once.
- R12: While dn_valid is 1 and dn_ready is 0, the downstream address and data stay stable. At most one downstream transaction is open at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Store request present |
| req_ready | output | 1 | Store completed this cycle (handshake) |
| req_strict | input | 1 | 1 = strictly ordered store, 0 = device store |
| req_addr | input | AW | Store address |
| req_data | input | DW | Store data |
| req_strb | input | DW/8 | Byte enables |
| req_err | output | 1 | Synchronous error, valid with req_ready on a strictly ordered store |
| bar_req | input | 1 | Barrier request (level) |
| bar_ack | output | 1 | Barrier satisfied |
| dn_valid | output | 1 | Downstream store request |
| dn_ready | input | 1 | Downstream accepts the request |
| dn_addr | output | AW | Downstream address |
| dn_data | output | DW | Downstream data |
| dn_strb | output | DW/8 | Downstream byte enables |
| dn_rsp_valid | input | 1 | Downstream response for the open transaction |
| dn_rsp_err | input | 1 | Downstream response carries an error |
| imp_err | output | 1 | Sticky error flag for early-completed stores |
| imp_addr | output | AW | Address of the store that set imp_err |
| err_clr | input | 1 | One-cycle clear of imp_err |

## Verification
The bench builds the block with a 16-bit address, a region field of the top four bits (REG_LSB = 12) and a queue of four entries. Regions can therefore be chosen directly from the leading hex digit of each address, and the queue can be filled in a handful of stores. The bench's downstream model can withhold dn_ready indefinitely and stretch the response latency. This lets it show a full queue stall, a strictly ordered store waiting behind its own region and passing a foreign one, and an error response landing in the same cycle as a clear pulse.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

    // Issue-stage sequencing towards the interconnect
    typedef enum logic [1:0] {
        ISS_IDLE = 2'd0,   // nothing open downstream
        ISS_REQ  = 2'd1,   // request presented, waiting for dn_ready
        ISS_WAIT = 2'd2    // accepted, waiting for the response
    } iss_state_e;

endpackage

// File: rtl/wbuf_fifo.sv
// In-order store queue with a per-entry region comparator.
// DEPTH must be a power of two: pointers wrap by overflow.
module wbuf_fifo #(
    parameter int AW      = 32,
    parameter int DW      = 32,
    parameter int DEPTH   = 4,
    parameter int REG_LSB = 28,
    localparam int SW     = DW / 8,
    localparam int PW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int RW     = AW - REG_LSB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_data,
    input  logic [SW-1:0] in_strb,
    input  logic          pop,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    output logic [SW-1:0] head_strb,
    output logic          full,
    output logic          empty,
    input  logic [RW-1:0] probe_region,
    output logic          probe_hit
);

    typedef struct packed {
        logic [DEPTH-1:0][AW-1:0] addr;
        logic [DEPTH-1:0][DW-1:0] data;
        logic [DEPTH-1:0][SW-1:0] strb;
        logic [PW-1:0]            wr;
        logic [PW-1:0]            rd;
        logic [PW:0]              cnt;
    } fifo_st_t;

    fifo_st_t st_q, st_d;
    logic [DEPTH-1:0] live;
    logic [DEPTH-1:0] hit;

    // One comparator per slot; a slot counts only while it is occupied
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        logic [PW-1:0] ofs;
        assign ofs      = PW'(gi) - st_q.rd;
        assign live[gi] = ({1'b0, ofs} < st_q.cnt);
        assign hit[gi]  = live[gi] && (st_q.addr[gi][AW-1:REG_LSB] == probe_region);
    end

    assign probe_hit = |hit;
    assign full      = (st_q.cnt == (PW+1)'(DEPTH));
    assign empty     = (st_q.cnt == '0);
    assign head_addr = st_q.addr[st_q.rd];
    assign head_data = st_q.data[st_q.rd];
    assign head_strb = st_q.strb[st_q.rd];

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.addr[st_q.wr] = in_addr;
            st_d.data[st_q.wr] = in_data;
            st_d.strb[st_q.wr] = in_strb;
            st_d.wr            = st_q.wr + 1'b1;
        end
        if (pop) begin
            st_d.rd = st_q.rd + 1'b1;
        end
        st_d.cnt = st_q.cnt + {{PW{1'b0}}, push} - {{PW{1'b0}}, pop};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/wbuf_issue.sv
// Single-outstanding issue stage. A strictly ordered store that is
// clear of its region takes priority over the queue head.
module wbuf_issue
    import wbuf_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 32,
    localparam int SW = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    // strictly ordered store, already cleared of same-region predecessors
    input  logic          strict_go,
    input  logic [AW-1:0] s_addr,
    input  logic [DW-1:0] s_data,
    input  logic [SW-1:0] s_strb,
    // queue head
    input  logic          q_empty,
    input  logic [AW-1:0] q_addr,
    input  logic [DW-1:0] q_data,
    input  logic [SW-1:0] q_strb,
    output logic          q_pop,
    // interconnect
    output logic          dn_valid,
    input  logic          dn_ready,
    output logic [AW-1:0] dn_addr,
    output logic [DW-1:0] dn_data,
    output logic [SW-1:0] dn_strb,
    input  logic          rsp_valid,
    input  logic          rsp_err,
    // completion reporting
    output logic          strict_done,
    output logic          strict_err,
    output logic          post_err,
    output logic [AW-1:0] post_err_addr,
    output logic          idle
);

    typedef struct packed {
        iss_state_e    state;
        logic          strict;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [SW-1:0] strb;
    } iss_st_t;

    iss_st_t st_q, st_d;

    always_comb begin
        st_d        = st_q;
        q_pop       = 1'b0;
        strict_done = 1'b0;
        strict_err  = 1'b0;
        post_err    = 1'b0;
        unique case (st_q.state)
            ISS_IDLE: begin
                if (strict_go) begin
                    st_d.state  = ISS_REQ;
                    st_d.strict = 1'b1;
                    st_d.addr   = s_addr;
                    st_d.data   = s_data;
                    st_d.strb   = s_strb;
                end else if (!q_empty) begin
                    q_pop       = 1'b1;
                    st_d.state  = ISS_REQ;
                    st_d.strict = 1'b0;
                    st_d.addr   = q_addr;
                    st_d.data   = q_data;
                    st_d.strb   = q_strb;
                end
            end
            ISS_REQ: begin
                if (dn_ready) begin
                    st_d.state = ISS_WAIT;
                end
            end
            ISS_WAIT: begin
                if (rsp_valid) begin
                    st_d.state = ISS_IDLE;
                    if (st_q.strict) begin
                        strict_done = 1'b1;
                        strict_err  = rsp_err;
                    end else begin
                        post_err    = rsp_err;
                    end
                end
            end
            default: begin
                st_d.state = ISS_IDLE;
            end
        endcase
    end

    assign dn_valid      = (st_q.state == ISS_REQ);
    assign dn_addr       = st_q.addr;
    assign dn_data       = st_q.data;
    assign dn_strb       = st_q.strb;
    assign post_err_addr = st_q.addr;
    assign idle          = (st_q.state == ISS_IDLE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/wbuf_errlog.sv
// Sticky error flag for early-completed stores; first error address kept.
module wbuf_errlog #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set,
    input  logic [AW-1:0] set_addr,
    input  logic          clr,
    output logic          flag,
    output logic [AW-1:0] addr
);

    typedef struct packed {
        logic          flag;
        logic [AW-1:0] addr;
    } log_st_t;

    log_st_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        // clear acts first, a new error in the same cycle wins
        st_d.flag = (st_q.flag & ~clr) | set;
        if (set && (!st_q.flag || clr)) begin
            st_d.addr = set_addr;
        end
    end

    assign flag = st_q.flag;
    assign addr = st_q.addr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/posted_wr_buf.sv
module posted_wr_buf #(
    parameter int AW      = 32,
    parameter int DW      = 32,
    parameter int DEPTH   = 4,
    parameter int REG_LSB = 28,
    localparam int SW     = DW / 8,
    localparam int RW     = AW - REG_LSB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_strict,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    input  logic [SW-1:0] req_strb,
    output logic          req_err,
    input  logic          bar_req,
    output logic          bar_ack,
    output logic          dn_valid,
    input  logic          dn_ready,
    output logic [AW-1:0] dn_addr,
    output logic [DW-1:0] dn_data,
    output logic [SW-1:0] dn_strb,
    input  logic          dn_rsp_valid,
    input  logic          dn_rsp_err,
    output logic          imp_err,
    output logic [AW-1:0] imp_addr,
    input  logic          err_clr
);

    logic          fifo_push;
    logic          fifo_pop;
    logic          fifo_full;
    logic          fifo_empty;
    logic [AW-1:0] head_addr;
    logic [DW-1:0] head_data;
    logic [SW-1:0] head_strb;
    logic          region_busy;
    logic          strict_go;
    logic          strict_done;
    logic          strict_err;
    logic          post_err;
    logic [AW-1:0] post_err_addr;
    logic          iss_idle;
    logic [RW-1:0] req_region;

    assign req_region = req_addr[AW-1:REG_LSB];

    // device stores complete on queue entry, strict ones on their response
    assign fifo_push = req_valid && !req_strict && !fifo_full;
    assign strict_go = req_valid && req_strict && !region_busy;
    assign req_ready = req_strict ? strict_done : !fifo_full;
    assign req_err   = strict_err;
    assign bar_ack   = bar_req && fifo_empty && iss_idle;

    wbuf_fifo #(
        .AW      (AW),
        .DW      (DW),
        .DEPTH   (DEPTH),
        .REG_LSB (REG_LSB)
    ) u_fifo (
        .clk          (clk),
        .rst_n        (rst_n),
        .push         (fifo_push),
        .in_addr      (req_addr),
        .in_data      (req_data),
        .in_strb      (req_strb),
        .pop          (fifo_pop),
        .head_addr    (head_addr),
        .head_data    (head_data),
        .head_strb    (head_strb),
        .full         (fifo_full),
        .empty        (fifo_empty),
        .probe_region (req_region),
        .probe_hit    (region_busy)
    );

    wbuf_issue #(
        .AW (AW),
        .DW (DW)
    ) u_issue (
        .clk           (clk),
        .rst_n         (rst_n),
        .strict_go     (strict_go),
        .s_addr        (req_addr),
        .s_data        (req_data),
        .s_strb        (req_strb),
        .q_empty       (fifo_empty),
        .q_addr        (head_addr),
        .q_data        (head_data),
        .q_strb        (head_strb),
        .q_pop         (fifo_pop),
        .dn_valid      (dn_valid),
        .dn_ready      (dn_ready),
        .dn_addr       (dn_addr),
        .dn_data       (dn_data),
        .dn_strb       (dn_strb),
        .rsp_valid     (dn_rsp_valid),
        .rsp_err       (dn_rsp_err),
        .strict_done   (strict_done),
        .strict_err    (strict_err),
        .post_err      (post_err),
        .post_err_addr (post_err_addr),
        .idle          (iss_idle)
    );

    wbuf_errlog #(
        .AW (AW)
    ) u_errlog (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      (post_err),
        .set_addr (post_err_addr),
        .clr      (err_clr),
        .flag     (imp_err),
        .addr     (imp_addr)
    );

endmodule

// File: rtl/wbuf_checker.sv
module wbuf_checker #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          req_strict,
    input logic          dn_valid,
    input logic          dn_ready,
    input logic [AW-1:0] dn_addr,
    input logic [DW-1:0] dn_data,
    input logic          dn_rsp_valid,
    input logic          bar_ack,
    input logic          imp_err,
    input logic          err_clr,
    input logic          fifo_pop
);

    logic [31:0] occ_q;   // device stores accepted and not yet moved to issue
    logic        open_q;  // downstream transaction accepted, response pending
    logic        dev_acc;

    assign dev_acc = req_valid && !req_strict && req_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q  <= '0;
            open_q <= 1'b0;
        end else begin
            occ_q <= occ_q + 32'(dev_acc) - 32'(fifo_pop);
            if (dn_valid && dn_ready) begin
                open_q <= 1'b1;
            end else if (dn_rsp_valid) begin
                open_q <= 1'b0;
            end
        end
    end

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= 32'(DEPTH));

    p_strict_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_strict && req_ready) |-> (dn_rsp_valid && open_q));

    p_sync_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_strict && req_ready && !err_clr) |=> $stable(imp_err));

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (imp_err && !err_clr) |=> imp_err);

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !dn_rsp_valid) |=> !imp_err);

    p_barrier_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bar_ack |-> (occ_q == '0 && !open_q && !dn_valid));

    p_hold_payload_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_addr) && $stable(dn_data)));

    p_single_open_r12: assert property (@(posedge clk) disable iff (!rst_n)
        open_q |-> !dn_valid);

endmodule

bind posted_wr_buf wbuf_checker #(
    .DEPTH (DEPTH),
    .AW    (AW),
    .DW    (DW)
) u_wbuf_checker (.*);

// File: tb/test_posted_wr_buf.sv
module test_posted_wr_buf;

    localparam int AW      = 16;
    localparam int DW      = 32;
    localparam int DEPTH   = 4;
    localparam int REG_LSB = 12;
    localparam int SW      = DW / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_strict = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic [SW-1:0] req_strb = '0;
    logic          req_err;
    logic          bar_req = 1'b0;
    logic          bar_ack;
    logic          dn_valid;
    logic          dn_ready = 1'b0;
    logic [AW-1:0] dn_addr;
    logic [DW-1:0] dn_data;
    logic [SW-1:0] dn_strb;
    logic          dn_rsp_valid = 1'b0;
    logic          dn_rsp_err = 1'b0;
    logic          imp_err;
    logic [AW-1:0] imp_addr;
    logic          err_clr = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    posted_wr_buf #(
        .AW      (AW),
        .DW      (DW),
        .DEPTH   (DEPTH),
        .REG_LSB (REG_LSB)
    ) i_posted_wr_buf (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_strict   (req_strict),
        .req_addr     (req_addr),
        .req_data     (req_data),
        .req_strb     (req_strb),
        .req_err      (req_err),
        .bar_req      (bar_req),
        .bar_ack      (bar_ack),
        .dn_valid     (dn_valid),
        .dn_ready     (dn_ready),
        .dn_addr      (dn_addr),
        .dn_data      (dn_data),
        .dn_strb      (dn_strb),
        .dn_rsp_valid (dn_rsp_valid),
        .dn_rsp_err   (dn_rsp_err),
        .imp_err      (imp_err),
        .imp_addr     (imp_addr),
        .err_clr      (err_clr)
    );

    int            n_cmp = 0;
    int            n_bad = 0;
    bit            finished = 1'b0;
    bit            hold = 1'b0;
    int            rsp_lat = 1;
    logic [AW-1:0] log_addr [64];
    int            log_n = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Downstream model: accepts when not held, answers after rsp_lat cycles,
    // flags an error for any address whose low byte is EE.
    initial begin
        bit            pend = 1'b0;
        bit            perr = 1'b0;
        int            lat = 0;
        bit            seen = 1'b0;
        logic [AW-1:0] seen_addr = '0;
        forever begin
            @(negedge clk);
            dn_rsp_valid = 1'b0;
            dn_rsp_err   = 1'b0;
            if (pend && dn_valid) begin
                chk("R12 second open transaction", 32'(dn_valid), 32'd0);
            end
            if (dn_ready) begin
                dn_ready = 1'b0;
                pend     = 1'b1;
                lat      = rsp_lat;
            end else if (pend) begin
                if (lat <= 1) begin
                    dn_rsp_valid = 1'b1;
                    dn_rsp_err   = perr;
                    pend         = 1'b0;
                end else begin
                    lat--;
                end
            end else if (dn_valid) begin
                if (!seen) begin
                    seen      = 1'b1;
                    seen_addr = dn_addr;
                end
                if (!hold) begin
                    chk("R12 payload held", 32'(dn_addr), 32'(seen_addr));
                    dn_ready = 1'b1;
                    perr     = (dn_addr[7:0] == 8'hEE);
                    if (log_n < 64) log_addr[log_n] = dn_addr;
                    log_n++;
                    seen = 1'b0;
                end
            end
        end
    end

    task automatic dev_write(input logic [AW-1:0] a, input int max_wait,
                             output int waited, output bit ok);
        @(negedge clk);
        req_valid  = 1'b1;
        req_strict = 1'b0;
        req_addr   = a;
        req_data   = {16'hD0D0, a};
        req_strb   = '1;
        waited     = 0;
        ok         = 1'b0;
        while (1) begin
            #1;
            if (req_ready) begin ok = 1'b1; break; end
            if (waited >= max_wait) break;
            waited++;
            @(negedge clk);
        end
        if (ok) @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic strict_write(input logic [AW-1:0] a, input int max_wait,
                                output bit ok, output bit err, output bit rsp_seen);
        int waited = 0;
        @(negedge clk);
        req_valid  = 1'b1;
        req_strict = 1'b1;
        req_addr   = a;
        req_data   = {16'h5A5A, a};
        req_strb   = '1;
        ok = 1'b0; err = 1'b0; rsp_seen = 1'b0;
        while (1) begin
            #1;
            if (req_ready) begin
                ok = 1'b1; err = req_err; rsp_seen = dn_rsp_valid;
                break;
            end
            if (waited >= max_wait) break;
            waited++;
            @(negedge clk);
        end
        if (ok) @(posedge clk);
        #1;
        req_valid  = 1'b0;
        req_strict = 1'b0;
    endtask

    task automatic barrier(input string tag, input bit expect_busy);
        bit got = 1'b0;
        @(negedge clk);
        bar_req = 1'b1;
        #1;
        if (expect_busy) chk({tag, " R10 ack withheld while busy"}, 32'(bar_ack), 32'd0);
        for (int i = 0; i < 300; i++) begin
            if (bar_ack) begin got = 1'b1; break; end
            @(negedge clk);
            #1;
        end
        chk({tag, " R10 barrier acknowledged"}, 32'(got), 32'd1);
        chk({tag, " R10 nothing open at ack"}, 32'(dn_valid), 32'd0);
        @(posedge clk);
        #1 bar_req = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        #1;
        chk("R11 ready after reset", 32'(req_ready), 32'd1);
        chk("R11 dn_valid after reset", 32'(dn_valid), 32'd0);
        chk("R11 imp_err after reset", 32'(imp_err), 32'd0);
        bar_req = 1'b1;
        #1;
        chk("R11 barrier immediate", 32'(bar_ack), 32'd1);
        bar_req = 1'b0;
    endtask

    task automatic t_posting();
        int w; bit ok;
        log_n = 0;
        hold  = 1'b1;
        for (int i = 0; i <= DEPTH; i++) begin
            dev_write(16'h1000 + 16'(i * 16), 0, w, ok);
            chk("R1 device store completes while stalled", 32'(ok), 32'd1);
        end
        dev_write(16'h1050, 3, w, ok);
        chk("R2 store beyond capacity stalls", 32'(ok), 32'd0);
        fork
            barrier("posting", 1'b1);
            begin repeat (3) @(negedge clk); hold = 1'b0; end
        join
        dev_write(16'h1050, 40, w, ok);
        chk("R2 stalled store accepted once space frees", 32'(ok), 32'd1);
        barrier("posting tail", 1'b0);
        chk("R3 count", 32'(log_n), 32'd6);
        for (int i = 0; i < 6; i++) begin
            chk("R3 same-region order", 32'(log_addr[i]), 32'h1000 + 32'(i * 16));
        end
    endtask

    task automatic t_strict_same_region();
        int w; bit ok, err, rs;
        log_n = 0;
        hold  = 1'b1;
        dev_write(16'h2010, 0, w, ok);
        dev_write(16'h2020, 0, w, ok);
        fork
            strict_write(16'h2030, 200, ok, err, rs);
            begin
                repeat (8) @(negedge clk);
                #2;
                chk("R4 strict store not completed early", 32'(req_ready), 32'd0);
                hold = 1'b0;
            end
        join
        chk("R4 strict store completes", 32'(ok), 32'd1);
        chk("R4 completion coincides with response", 32'(rs), 32'd1);
        chk("R7 no error on clean strict store", 32'(err), 32'd0);
        barrier("strict", 1'b0);
        chk("R5 first", 32'(log_addr[0]), 32'h2010);
        chk("R5 second", 32'(log_addr[1]), 32'h2020);
        chk("R5 strict after its region", 32'(log_addr[2]), 32'h2030);
    endtask

    task automatic t_bypass();
        int w; bit ok, err, rs;
        log_n = 0;
        hold  = 1'b1;
        dev_write(16'h3010, 0, w, ok);
        dev_write(16'h3020, 0, w, ok);
        dev_write(16'h3030, 0, w, ok);
        fork
            strict_write(16'h5040, 200, ok, err, rs);
            begin repeat (4) @(negedge clk); hold = 1'b0; end
        join
        barrier("bypass", 1'b0);
        chk("R6 issue-stage store first", 32'(log_addr[0]), 32'h3010);
        chk("R6 strict passes other region", 32'(log_addr[1]), 32'h5040);
        chk("R6 queued third", 32'(log_addr[2]), 32'h3020);
        chk("R6 queued fourth", 32'(log_addr[3]), 32'h3030);
    endtask

    task automatic t_sync_err();
        bit ok, err, rs;
        strict_write(16'h60EE, 200, ok, err, rs);
        chk("R7 strict error returned synchronously", 32'(err), 32'd1);
        #1;
        chk("R7 sticky flag untouched", 32'(imp_err), 32'd0);
        strict_write(16'h6010, 200, ok, err, rs);
        chk("R7 following clean strict store", 32'(err), 32'd0);
    endtask

    task automatic t_posted_err();
        int w; bit ok;
        dev_write(16'h70EE, 0, w, ok);
        chk("R1 erroring store still completes early", 32'(ok), 32'd1);
        barrier("perr", 1'b0);
        chk("R8 flag set", 32'(imp_err), 32'd1);
        chk("R8 address captured", 32'(imp_addr), 32'h70EE);
        dev_write(16'h71EE, 0, w, ok);
        barrier("perr2", 1'b0);
        chk("R8 flag still set", 32'(imp_err), 32'd1);
        chk("R8 first address kept", 32'(imp_addr), 32'h70EE);
    endtask

    task automatic t_clear();
        int w; bit ok; bit hit = 1'b0;
        @(negedge clk);
        err_clr = 1'b1;
        @(posedge clk);
        #1 err_clr = 1'b0;
        chk("R9 clear pulse", 32'(imp_err), 32'd0);
        dev_write(16'h73EE, 0, w, ok);
        barrier("clr", 1'b0);
        chk("R9 flag raised again", 32'(imp_err), 32'd1);
        rsp_lat = 4;
        dev_write(16'h74EE, 0, w, ok);
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            #1;
            if (dn_rsp_valid) begin
                err_clr = 1'b1;
                @(posedge clk);
                #1 err_clr = 1'b0;
                hit = 1'b1;
                break;
            end
        end
        rsp_lat = 1;
        chk("R9 coincidence reached", 32'(hit), 32'd1);
        chk("R9 error wins over clear", 32'(imp_err), 32'd1);
        chk("R9 new address loaded", 32'(imp_addr), 32'h74EE);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_posting();
        t_strict_same_region();
        t_bypass();
        t_sync_err();
        t_posted_err();
        t_clear();
        repeat (4) @(negedge clk);
        summary();
    end

endmodule